// File: doc/BRIEF.md
# Watchdog Timer with Guarded Shutdown

The watchdog counts clock cycles while it is armed and raises a one-cycle reset request when software lets the count reach the selected limit without restarting it. Software restarts the count with a single-cycle strobe. A small control word holds the arm bit, a 3-bit prescaler code and a shutdown-unlock bit. The timeout length is 2^(code+10) cycles.

A stray write cannot turn the watchdog off. Software first writes the unlock bit and the arm bit as 1 in the same write. This opens a short window. A later write that clears the arm bit disarms the watchdog only while that window is open. The window closes by itself four cycles after it opens. While the watchdog is armed and locked, the prescaler code is frozen, so a runaway program cannot lengthen the timeout either.

Top module: `wdog_guard`

## Requirements
- R1: After reset the control readback is all zeros (unlock bit 4, arm bit 3, prescaler bits 2:0) and the reset request output is low.
- R2: A write of 1 to the arm bit while disarmed arms the watchdog. With a count of zero, the reset request rises on the 2^(code+10)-th clock edge after the arming write.
- R3: The reset request is high for exactly one cycle. The count then starts again from zero, so the next request follows 2^(code+10) cycles later.
- R4: A restart strobe clears the count. The next request comes 2^(code+10) edges after the strobe edge, and none is raised on the cycle after a strobe.
- R5: A single write with both the unlock bit (bit 4) and the arm bit (bit 3) at 1 opens the shutdown window, and the unlock bit then reads back as 1.
- R6: A write with the arm bit at 0 on any of the four clock edges after the opening write disarms the watchdog.
- R7: While armed, a write that clears the arm bit and arrives outside the window is ignored. This includes the fifth edge after the opening write and writes made with no opening write at all.
- R8: The unlock bit is set only while the watchdog is armed. It reads back as 1 after the opening edge and the three edges that follow, and it returns to 0 by itself after the fourth.
- R9: While armed and outside the window, prescaler writes are ignored. Inside the window, or while disarmed, they take effect.
- R10: While disarmed, no reset request is ever raised.
- R11: An opening write that carries the unlock bit with the arm bit at 0 does not open the window and does not disarm the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 5 | Control write data: bit 4 unlock, bit 3 arm, bits 2:0 prescaler code |
| ctl_rdata | output | 5 | Control readback, same layout as the write data |
| kick | input | 1 | Restart strobe, clears the count |
| wdt_rst | output | 1 | One-cycle timeout reset request |

## Verification
The bench sweeps the distance between the opening write and the disarming write from one to six edges. An off-by-one window would either accept the fifth edge or reject the fourth. It also measures the exact timeout length after arming, after a pulse and after a restart. A counter that compared against the wrong limit, or did not wrap after a pulse, would shift every measured interval. Further cases cover a stretched pulse, a disarm without the opening write, an opening write with the arm bit clear, and a prescaler change while locked. Each of these would show up as a wrong readback or a wrong interval.

// File: rtl/wdog_guard.sv
module wdog_guard #(
  parameter int PS_W     = 3,
  parameter int BASE_EXP = 10,
  parameter int WIN_LEN  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_we,
  input  logic [PS_W+1:0] ctl_wdata,
  output logic [PS_W+1:0] ctl_rdata,
  input  logic            kick,
  output logic            wdt_rst
);
  localparam int CNT_W = BASE_EXP + (1 << PS_W) - 1;
  localparam int WIN_W = $clog2(WIN_LEN + 1);

  logic             en_q;
  logic [PS_W-1:0]  ps_q;
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rst_q;

  wire             toe_q    = (win_q != '0);
  wire             wr_toe   = ctl_wdata[PS_W+1];
  wire             wr_en    = ctl_wdata[PS_W];
  wire [PS_W-1:0]  wr_ps    = ctl_wdata[PS_W-1:0];
  wire             open_req = ctl_we & wr_toe & wr_en;
  wire             unlocked = ~en_q | toe_q;
  wire [CNT_W-1:0] last     = ~({CNT_W{1'b1}} << (BASE_EXP + ps_q));
  wire             hit      = en_q & ~kick & (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ps_q  <= '0;
      win_q <= '0;
    end else if (ctl_we) begin
      if (open_req) begin
        en_q  <= 1'b1;
        win_q <= WIN_W'(WIN_LEN);
        if (unlocked) ps_q <= wr_ps;
      end else begin
        win_q <= '0;
        if (unlocked) begin
          en_q <= wr_en;
          ps_q <= wr_ps;
        end
      end
    end else if (toe_q) begin
      win_q <= win_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= hit;
      if (kick || hit) cnt_q <= '0;
      else if (en_q)   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ctl_rdata = {toe_q, en_q, ps_q};
  assign wdt_rst   = rst_q;

  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);
  p_kick_defers_r4: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !wdt_rst);
  p_open_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    open_req |=> toe_q);
  p_en_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !toe_q) |=> en_q);
  p_toe_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    toe_q |-> en_q);
  p_win_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_q <= WIN_W'(WIN_LEN));
  p_ps_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !toe_q) |=> $stable(ps_q));
  p_quiet_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !wdt_rst);
endmodule

// File: tb/wdog_guard_tb.sv
`timescale 1ns/1ps
module wdog_guard_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [4:0] ctl_wdata = '0;
  logic [4:0] ctl_rdata;
  logic       kick = 1'b0;
  logic       wdt_rst;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wdog_guard u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .kick(kick), .wdt_rst(wdt_rst)
  );

  // {gap from opening write to disarm write, expected arm bit afterwards}
  localparam logic [4:0] TAB [6] = '{
    {4'd1, 1'b0}, {4'd2, 1'b0}, {4'd3, 1'b0},
    {4'd4, 1'b0}, {4'd5, 1'b1}, {4'd6, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] d);
    ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_we = 1'b0; ctl_wdata = '0;
  endtask

  task automatic do_kick();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!wdt_rst && n < 5000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int pulses;
    do_reset();
    chk(ctl_rdata == 5'd0, "R1 readback", ctl_rdata, 0);
    chk(wdt_rst == 1'b0, "R1 request", wdt_rst, 0);

    pulses = 0;
    for (int i = 0; i < 1100; i++) begin
      @(negedge clk);
      if (wdt_rst) pulses++;
    end
    chk(pulses == 0, "R10 disarmed pulses", pulses, 0);

    wr(5'b01000);
    measure(n);
    chk(n == 1024, "R2 first timeout", n, 1024);
    @(negedge clk);
    chk(wdt_rst == 1'b0, "R3 pulse width", wdt_rst, 0);
    measure(n);
    chk(n == 1023, "R3 wrap interval", n, 1023);

    repeat (500) @(negedge clk);
    do_kick();
    chk(wdt_rst == 1'b0, "R4 no pulse after kick", wdt_rst, 0);
    measure(n);
    chk(n == 1024, "R4 after kick", n, 1024);

    wr(5'b00000);
    chk(ctl_rdata[3] == 1'b1, "R7 disarm without unlock", ctl_rdata[3], 1);
    wr(5'b10000);
    chk(ctl_rdata == 5'b01000, "R11 unlock with arm clear", ctl_rdata, 5'b01000);
    wr(5'b01010);
    chk(ctl_rdata[2:0] == 3'd0, "R9 locked prescaler", ctl_rdata[2:0], 0);
    wr(5'b11001);
    chk(ctl_rdata[4] == 1'b1, "R5 window opened", ctl_rdata[4], 1);
    wr(5'b01001);
    chk(ctl_rdata == 5'b01001, "R9 prescaler in window", ctl_rdata, 5'b01001);
    do_kick();
    measure(n);
    chk(n == 2048, "R9 new timeout", n, 2048);

    do_reset();
    wr(5'b01000);
    wr(5'b11000);
    chk(ctl_rdata[4] == 1'b1, "R8 unlock after open", ctl_rdata[4], 1);
    for (int j = 1; j <= 4; j++) begin
      @(negedge clk);
      chk(ctl_rdata[4] == (j < 4), "R8 unlock self clear", ctl_rdata[4], int'(j < 4));
    end
    wr(5'b00000);
    chk(ctl_rdata[3] == 1'b1, "R7 after window closed", ctl_rdata[3], 1);

    for (int i = 0; i < 6; i++) begin
      do_reset();
      wr(5'b01000);
      wr(5'b11000);
      repeat (int'(TAB[i][4:1]) - 1) @(negedge clk);
      wr(5'b00000);
      chk(ctl_rdata[3] == TAB[i][0], TAB[i][0] ? "R7 late disarm" : "R6 disarm in window",
          ctl_rdata[3], TAB[i][0]);
    end

    do_reset();
    wr(5'b01000);
    wr(5'b11000);
    wr(5'b00000);
    pulses = 0;
    for (int i = 0; i < 1100; i++) begin
      @(negedge clk);
      if (wdt_rst) pulses++;
    end
    chk(pulses == 0, "R10 after disarm", pulses, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule